// File: doc/BRIEF.md
# Wormhole Route Unit with Credit Flow Control

This unit serves one input port of a token switch. Tokens are 9 bits wide: bit 8 set marks a control token, clear marks a data token, and bits 7:0 carry the byte. The first two data tokens of a message form a 16-bit destination, high byte first. If the destination equals this node's address, the message is delivered to the local output. Otherwise the most significant bit where destination and node address differ selects an entry of a 16-entry direction table, and that entry names the output link. The route then stays open until an END control token (`9'h101`) or a PAUSE control token (`9'h102`) passes. A message that never closes holds its route like a circuit.

Each output link has a 7-bit credit counter that the downstream receiver fills through a 2-bit grant code. Every token sent on a link uses one credit. With no credit the unit holds back the header tokens, or drops its input ready while forwarding. All outputs share one registered token bus, and a per-link valid strobe marks which link it is for.

Top module: `route_unit`

## Requirements
- R1: After reset `tok_ready_o` is 1, `out_valid_o`, `loc_valid_o` and `credit_err_o` are 0, and every credit count is 0.
- R2: For a destination other than the node address, the link is the direction table entry indexed by the highest bit position (bits scanned 15 down to 0) where destination and node address differ. The two header tokens are sent on that link first, as data tokens, high byte first.
- R3: No token is sent on a link whose credit count is 0. While the open route's link has no credit, `tok_ready_o` is 0, and it returns to 1 once a grant arrives.
- R4: Grant code per link in `grant_i[2k+1:2k]`: 2'b00 none, 2'b01 adds 8, 2'b10 adds 32, 2'b11 adds 64 credits. Each token sent on a link uses one credit.
- R5: A grant that would take a count above 127 leaves it at 127 and sets `credit_err_o[k]`, which stays set until reset.
- R6: Once a route is open, every following token, including control tokens other than END and PAUSE, goes out on the same link in arrival order. END and PAUSE are forwarded on a remote route and close it, so the next data token starts a new header.
- R7: A destination equal to the node address sends the message's tokens to `loc_tok_o`. The two header tokens are not delivered and no output link is used.
- R8: On a local route END is delivered and closes the route. PAUSE closes the route and never appears on `loc_tok_o`.
- R9: A control token arriving when no route is open is discarded. If it arrives between the two header bytes, the partial header is abandoned.
- R10: `cfg_addr_we_i` loads the node address, and `cfg_dir_we_i` loads table entry `cfg_dir_idx_i` with `cfg_dir_link_i`. Later messages route by the new values.
- R11: A token accepted at a clock edge appears on its output (link or local) right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_addr_we_i | input | 1 | Write strobe for the node address |
| cfg_addr_i | input | 16 | Node address value |
| cfg_dir_we_i | input | 1 | Write strobe for a direction table entry |
| cfg_dir_idx_i | input | 4 | Table entry (address bit position) |
| cfg_dir_link_i | input | LINK_W | Output link stored in the entry |
| tok_valid_i | input | 1 | Input token valid |
| tok_i | input | 9 | Input token, bit 8 is the control flag |
| tok_ready_o | output | 1 | Input token accepted when high with valid |
| out_valid_o | output | N_OUT | Per-link strobe: `out_tok_o` is for this link |
| out_tok_o | output | 9 | Token bus shared by all links |
| grant_i | input | 2*N_OUT | Per-link 2-bit credit grant code |
| credit_err_o | output | N_OUT | Sticky per-link credit overflow flag |
| loc_valid_o | output | 1 | Local delivery strobe |
| loc_tok_o | output | 9 | Token for the local node |

## Verification
A token accepted at an edge shows up on its link or the local output right after that edge, so the bench samples at the following falling edge. On a remote route, the two header tokens go out on the first and second edges after the low header byte is accepted, provided the link holds credit. Forwarding then starts. A grant code applied before an edge counts from that edge, so a stalled input shows ready again at the next falling edge. The bench waits for these counts, or for a few extra idle cycles, before it reads the capture log or the strobes. It counts accepted tokens against the exact credit balance: 32 credits, and a clamped 127.

// File: rtl/route_pkg.sv
package route_pkg;
  localparam int unsigned TOK_W  = 9;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned IDX_W  = $clog2(ADDR_W);

  typedef logic [TOK_W-1:0] tok_t;

  localparam tok_t TOK_END   = 9'h101;
  localparam tok_t TOK_PAUSE = 9'h102;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR_LO,
    ST_EMIT_HI,
    ST_EMIT_LO,
    ST_FWD,
    ST_LOCAL
  } route_st_e;
endpackage

// File: rtl/route_credit_ctr.sv
module route_credit_ctr #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       grant_i,
  input  logic             use_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             err_o
);
  localparam int unsigned SUM_W   = CNT_W + 1;
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  logic [SUM_W-1:0] amt, sum;

  always_comb begin
    unique case (grant_i)
      2'b01:   amt = SUM_W'(8);
      2'b10:   amt = SUM_W'(32);
      2'b11:   amt = SUM_W'(64);
      default: amt = '0;
    endcase
    sum = SUM_W'(cnt_o) + amt - SUM_W'(use_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      err_o <= 1'b0;
    end else if (sum > SUM_W'(CNT_MAX)) begin
      cnt_o <= CNT_W'(CNT_MAX);
      err_o <= 1'b1;
    end else begin
      cnt_o <= sum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/route_sel.sv
module route_sel
  import route_pkg::*;
#(
  parameter int unsigned LINK_W = 2
) (
  input  logic [ADDR_W-1:0]             dest_i,
  input  logic [ADDR_W-1:0]             node_i,
  input  logic [ADDR_W-1:0][LINK_W-1:0] dir_i,
  output logic                          local_o,
  output logic [LINK_W-1:0]             link_o
);
  logic [ADDR_W-1:0] diff;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    diff    = dest_i ^ node_i;
    local_o = (diff == '0);
    idx     = '0;
    // ascending scan: the highest differing bit wins
    for (int i = 0; i < ADDR_W; i++) begin
      if (diff[i]) idx = IDX_W'(i);
    end
    link_o = dir_i[idx];
  end
endmodule

// File: rtl/route_unit.sv
module route_unit
  import route_pkg::*;
#(
  parameter int unsigned N_OUT    = 4,
  parameter int unsigned CNT_W    = 7,
  parameter logic [15:0] NODE_RST = 16'h0000,
  localparam int unsigned LINK_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_addr_we_i,
  input  logic [15:0]        cfg_addr_i,
  input  logic               cfg_dir_we_i,
  input  logic [3:0]         cfg_dir_idx_i,
  input  logic [LINK_W-1:0]  cfg_dir_link_i,
  input  logic               tok_valid_i,
  input  logic [8:0]         tok_i,
  output logic               tok_ready_o,
  output logic [N_OUT-1:0]   out_valid_o,
  output logic [8:0]         out_tok_o,
  input  logic [2*N_OUT-1:0] grant_i,
  output logic [N_OUT-1:0]   credit_err_o,
  output logic               loc_valid_o,
  output logic [8:0]         loc_tok_o
);
  route_st_e st_q, st_d;
  logic [ADDR_W-1:0]             node_q, dest_q;
  logic [ADDR_W-1:0][LINK_W-1:0] dir_q;
  logic [7:0]                    hi_q;
  logic [LINK_W-1:0]             link_q, sel_link;
  logic                          sel_local;
  logic [N_OUT-1:0][CNT_W-1:0]   cnt;
  logic [N_OUT-1:0]              cnt_nz, use_v;
  logic                          send, loc_v, acc, is_close;
  tok_t                          snd_tok;

  route_sel #(.LINK_W(LINK_W)) i_sel (
    .dest_i  ({hi_q, tok_i[7:0]}),
    .node_i  (node_q),
    .dir_i   (dir_q),
    .local_o (sel_local),
    .link_o  (sel_link)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_link
    assign cnt_nz[k] = |cnt[k];
    assign use_v[k]  = send && (link_q == LINK_W'(k));
    route_credit_ctr #(.CNT_W(CNT_W)) i_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .grant_i (grant_i[2*k +: 2]),
      .use_i   (use_v[k]),
      .cnt_o   (cnt[k]),
      .err_o   (credit_err_o[k])
    );
  end

  assign is_close = (tok_i == TOK_END) || (tok_i == TOK_PAUSE);
  assign acc      = tok_valid_i && tok_ready_o;

  always_comb begin
    st_d        = st_q;
    tok_ready_o = 1'b0;
    send        = 1'b0;
    loc_v       = 1'b0;
    snd_tok     = tok_i;
    unique case (st_q)
      ST_IDLE: begin
        tok_ready_o = 1'b1;
        if (tok_valid_i && !tok_i[8]) st_d = ST_HDR_LO;
      end
      ST_HDR_LO: begin
        tok_ready_o = 1'b1;
        if (tok_valid_i) begin
          if (tok_i[8])       st_d = ST_IDLE;
          else if (sel_local) st_d = ST_LOCAL;
          else                st_d = ST_EMIT_HI;
        end
      end
      ST_EMIT_HI: begin
        snd_tok = {1'b0, dest_q[15:8]};
        if (cnt_nz[link_q]) begin
          send = 1'b1;
          st_d = ST_EMIT_LO;
        end
      end
      ST_EMIT_LO: begin
        snd_tok = {1'b0, dest_q[7:0]};
        if (cnt_nz[link_q]) begin
          send = 1'b1;
          st_d = ST_FWD;
        end
      end
      ST_FWD: begin
        tok_ready_o = cnt_nz[link_q];
        if (acc) begin
          send = 1'b1;
          if (is_close) st_d = ST_IDLE;
        end
      end
      ST_LOCAL: begin
        tok_ready_o = 1'b1;
        if (tok_valid_i) begin
          loc_v = (tok_i != TOK_PAUSE);
          if (is_close) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      node_q      <= NODE_RST;
      dir_q       <= '0;
      hi_q        <= '0;
      dest_q      <= '0;
      link_q      <= '0;
      out_valid_o <= '0;
      out_tok_o   <= '0;
      loc_valid_o <= 1'b0;
      loc_tok_o   <= '0;
    end else begin
      st_q <= st_d;
      if (cfg_addr_we_i) node_q <= cfg_addr_i;
      if (cfg_dir_we_i)  dir_q[cfg_dir_idx_i] <= cfg_dir_link_i;
      if (st_q == ST_IDLE && tok_valid_i && !tok_i[8]) hi_q <= tok_i[7:0];
      if (st_q == ST_HDR_LO && tok_valid_i && !tok_i[8]) begin
        dest_q <= {hi_q, tok_i[7:0]};
        link_q <= sel_link;
      end
      out_valid_o <= use_v;
      if (send) out_tok_o <= snd_tok;
      loc_valid_o <= loc_v;
      if (loc_v) loc_tok_o <= tok_i;
    end
  end
endmodule

// File: rtl/route_unit_chk.sv
module route_unit_chk #(
  parameter int unsigned N_OUT = 4,
  parameter int unsigned CNT_W = 7
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        tok_valid_i,
  input logic                        tok_ready_o,
  input logic [N_OUT-1:0]            out_valid_o,
  input logic [N_OUT-1:0]            credit_err_o,
  input logic                        loc_valid_o,
  input logic [8:0]                  loc_tok_o,
  input logic [N_OUT-1:0][CNT_W-1:0] cnt_i
);
  p_one_link_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_valid_o));

  p_pause_not_local_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_valid_o |-> (loc_tok_o != 9'h102));

  p_local_latency_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_valid_o |-> $past(tok_valid_i && tok_ready_o));

  for (genvar k = 0; k < N_OUT; k++) begin : g_chk
    p_credit_before_send_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[k] |-> ($past(cnt_i[k]) != '0));

    p_err_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      credit_err_o[k] |=> credit_err_o[k]);
  end
endmodule

bind route_unit route_unit_chk #(.N_OUT(N_OUT), .CNT_W(CNT_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tok_valid_i  (tok_valid_i),
  .tok_ready_o  (tok_ready_o),
  .out_valid_o  (out_valid_o),
  .credit_err_o (credit_err_o),
  .loc_valid_o  (loc_valid_o),
  .loc_tok_o    (loc_tok_o),
  .cnt_i        (cnt)
);

// File: tb/test_route_unit.sv
`timescale 1ns/1ps
module test_route_unit;
  localparam int N_OUT = 4;
  localparam int LW    = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_addr_we = 1'b0;
  logic [15:0]      cfg_addr = '0;
  logic             cfg_dir_we = 1'b0;
  logic [3:0]       cfg_dir_idx = '0;
  logic [LW-1:0]    cfg_dir_link = '0;
  logic             tok_valid = 1'b0;
  logic [8:0]       tok = '0;
  logic             tok_ready;
  logic [N_OUT-1:0] out_valid;
  logic [8:0]       out_tok;
  logic [2*N_OUT-1:0] grant = '0;
  logic [N_OUT-1:0] credit_err;
  logic             loc_valid;
  logic [8:0]       loc_tok;

  always #4 clk = ~clk;

  route_unit #(.N_OUT(N_OUT)) i_route_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_addr_we_i(cfg_addr_we), .cfg_addr_i(cfg_addr),
    .cfg_dir_we_i(cfg_dir_we), .cfg_dir_idx_i(cfg_dir_idx), .cfg_dir_link_i(cfg_dir_link),
    .tok_valid_i(tok_valid), .tok_i(tok), .tok_ready_o(tok_ready),
    .out_valid_o(out_valid), .out_tok_o(out_tok), .grant_i(grant),
    .credit_err_o(credit_err), .loc_valid_o(loc_valid), .loc_tok_o(loc_tok)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int          cap_n = 0, loc_n = 0;
  int          cap_link [512];
  logic [8:0]  cap_tok  [512];
  logic [8:0]  loc_log  [64];

  always @(negedge clk) begin
    for (int k = 0; k < N_OUT; k++) begin
      if (out_valid[k] && cap_n < 512) begin
        cap_link[cap_n] = k;
        cap_tok[cap_n]  = out_tok;
        cap_n++;
      end
    end
    if (loc_valid && loc_n < 64) begin
      loc_log[loc_n] = loc_tok;
      loc_n++;
    end
  end

  // {dest, expected link, closing token}; node 16'hA5C3, dir[i] = (i+1)%4
  localparam logic [26:0] VEC [6] = '{
    {16'h25C3, 2'd0, 9'h101},
    {16'hE5C3, 2'd3, 9'h102},
    {16'hA5C2, 2'd1, 9'h101},
    {16'hA5C1, 2'd2, 9'h102},
    {16'hA4C3, 2'd1, 9'h101},
    {16'hA5E3, 2'd2, 9'h101}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic send(input logic [8:0] t);
    @(negedge clk);
    tok_valid = 1'b1;
    tok = t;
    while (!tok_ready) @(negedge clk);
    @(posedge clk);
    #1 tok_valid = 1'b0;
  endtask

  task automatic give(input logic [2*N_OUT-1:0] g);
    @(negedge clk);
    grant = g;
    @(negedge clk);
    grant = '0;
  endtask

  task automatic stream(input int cycles, output int n);
    n = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      tok_valid = 1'b1;
      tok = 9'h077;
      if (tok_ready) n++;
    end
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tok_valid = 1'b0;
    grant = '0;
    idle(2);
    rst_n = 1'b1;
    cap_n = 0;
    loc_n = 0;
  endtask

  task automatic config_all();
    @(negedge clk);
    cfg_addr_we = 1'b1;
    cfg_addr = 16'hA5C3;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      cfg_addr_we = 1'b0;
      cfg_dir_we = 1'b1;
      cfg_dir_idx = 4'(i);
      cfg_dir_link = LW'((i + 1) % 4);
    end
    @(negedge clk);
    cfg_dir_we = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n, base;
    idle(2);
    #1;
    // R1: reset state
    chk("R1 ready", 32'(tok_ready), 1);
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 loc_valid", 32'(loc_valid), 0);
    chk("R1 credit_err", 32'(credit_err), 0);
    rst_n = 1'b1;
    config_all();

    // R2 R4 R6: vector walk, route choice and ordered forwarding
    for (int v = 0; v < 6; v++) begin
      base = cap_n;
      give(8'b01010101);
      send({1'b0, VEC[v][26:19]});
      send({1'b0, VEC[v][18:11]});
      send(9'h05A);
      send(9'h1F0);
      send(VEC[v][8:0]);
      idle(3);
      chk("R2 token count", 32'(cap_n - base), 5);
      for (int j = 0; j < 5; j++)
        chk("R2 link", 32'(cap_link[base + j]), 32'(VEC[v][10:9]));
      chk("R2 header hi", 32'(cap_tok[base]),     32'({1'b0, VEC[v][26:19]}));
      chk("R2 header lo", 32'(cap_tok[base + 1]), 32'({1'b0, VEC[v][18:11]}));
      chk("R6 payload", 32'(cap_tok[base + 2]), 32'h05A);
      chk("R6 ctrl passthru", 32'(cap_tok[base + 3]), 32'h1F0);
      chk("R6 closing token", 32'(cap_tok[base + 4]), 32'(VEC[v][8:0]));
    end

    // R10: rewrite table entry 15 to link 2
    @(negedge clk);
    cfg_dir_we = 1'b1; cfg_dir_idx = 4'd15; cfg_dir_link = 2'd2;
    @(negedge clk);
    cfg_dir_we = 1'b0;
    base = cap_n;
    give(8'b00010000);
    send(9'h025); send(9'h0C3); send(9'h101);
    idle(3);
    chk("R10 count", 32'(cap_n - base), 3);
    chk("R10 new link", 32'(cap_link[base]), 2);

    // R9: control token with no route, and between header bytes
    base = cap_n;
    send(9'h1F0);
    send(9'h025);
    send(9'h1F1);
    send(9'h0A5); send(9'h0C2); send(9'h101);
    idle(3);
    chk("R9 count", 32'(cap_n - base), 3);
    chk("R9 link", 32'(cap_link[base]), 1);
    chk("R9 header hi", 32'(cap_tok[base]), 32'h0A5);
    chk("R9 header lo", 32'(cap_tok[base + 1]), 32'h0C2);
    chk("R9 no local", 32'(loc_n), 0);

    // R7 R8 R11: local delivery
    base = cap_n;
    send(9'h0A5); send(9'h0C3);
    send(9'h033);
    @(negedge clk);
    chk("R11 local strobe", 32'(loc_valid), 1);
    chk("R11 local token", 32'(loc_tok), 32'h033);
    send(9'h1F0);
    send(9'h102);
    send(9'h0A5); send(9'h0C3);
    send(9'h022);
    send(9'h101);
    idle(3);
    chk("R7 local count", 32'(loc_n), 4);
    chk("R7 local first", 32'(loc_log[0]), 32'h033);
    chk("R7 local ctrl", 32'(loc_log[1]), 32'h1F0);
    chk("R8 pause dropped", 32'(loc_log[2]), 32'h022);
    chk("R8 end delivered", 32'(loc_log[3]), 32'h101);
    chk("R7 no link used", 32'(cap_n - base), 0);

    // R3 R4: stall without credit, then a 32 grant
    do_reset();
    config_all();
    send(9'h025); send(9'h0C3);
    idle(5);
    chk("R3 nothing sent", 32'(cap_n), 0);
    chk("R3 ready low", 32'(tok_ready), 0);
    give(8'b00000010);
    idle(3);
    chk("R3 header after grant", 32'(cap_n), 2);
    stream(45, n);
    chk("R4 32 credits", 32'(n), 30);
    idle(1);
    chk("R3 stalled ready", 32'(tok_ready), 0);
    chk("R4 link0 total", 32'(cap_n), 32);
    give(8'b00000001);
    idle(1);
    chk("R3 ready after grant", 32'(tok_ready), 1);
    send(9'h101);
    idle(2);

    // R5: 64+64 clamps at 127 and flags
    do_reset();
    config_all();
    give(8'b00001100);
    idle(1);
    chk("R5 no err yet", 32'(credit_err), 0);
    give(8'b00001100);
    idle(1);
    chk("R5 err link1", 32'(credit_err), 32'b0010);
    send(9'h0A5); send(9'h0C2);
    idle(3);
    stream(140, n);
    idle(2);
    chk("R5 clamped credits", 32'(n), 125);
    chk("R5 tokens on link1", 32'(cap_n), 127);
    give(8'b00000100);
    send(9'h101);
    idle(3);
    chk("R5 close after grant", 32'(cap_n), 128);
    chk("R5 err stays", 32'(credit_err), 32'b0010);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule